// File: doc/BRIEF.md
# Frame-Boundary Configuration Reload Controller

This block sits beside a frame-based pixel engine and refreshes its configuration registers from memory between frames. Software places the memory address of a register descriptor in a next-descriptor pointer register. That write stores the address and raises a pending flag. When the running frame ends, the controller reads the descriptor one 32-bit word at a time over a request/response memory port. It copies the words into the engine's configuration slots, raises a one-cycle interrupt and then strobes the start of the next frame.

If the engine is idle when the pointer is written, the descriptor fetch begins at once. A write to the clear alias of the pointer cancels a reload that has not yet begun. Writes to the set and toggle aliases are not valid ways to use the pointer, and they are ignored. Some slots are never reloaded: the status slot, the three colour-conversion coefficient slots, the pointer slot and the version slot. Reserved bit fields of the loaded slots are forced to zero.

Top module: `frame_reload_ctrl`

## Requirements
- R1: After reset every output is zero, and no memory request is made.
- R2: A write to offset 0x100 stores the data as the pointer and raises the pending flag on the next cycle. While the engine runs, no memory request is made before the frame ends.
- R3: A write to offset 0x100 while the engine is idle starts the fetch, and the first memory request is visible on the next cycle.
- R4: Writes to offset 0x104 (set alias) or 0x10C (toggle alias) change neither the pointer nor the pending flag, and start no fetch.
- R5: A write to offset 0x108 (clear alias) drops the pending flag. A frame end that follows then returns the engine to idle, with no fetch and no interrupt.
- R6: At a frame end with a reload pending, the fetch runs. The interrupt follows in the cycle after the last response. The frame-start strobe follows one cycle later, and the engine is running the cycle after that.
- R7: The fetch reads NREG words from pointer+4*i for i = 0..NREG-1, in ascending order, with one request outstanding at a time. A request that is not accepted stays valid with a stable address.
- R8: Slots 0, 8, 9, 10, 13 and 15 are never loaded and always read zero. Every other slot i takes word i of the descriptor.
- R9: In odd-numbered loaded slots, bits 31:27 and 15:11 are reserved and always read zero.
- R10: The pending flag clears when the fetch completes. A pointer write made during a fetch is stored and stays pending for the next frame end.
- R11: The interrupt is high for exactly one cycle and sets a sticky status bit. A write to offset 0x000 with data bit 0 set clears that bit.
- R12: A frame end with nothing pending returns the engine to idle, with no frame-start strobe.
- R13: A start pulse while idle gives a frame-start strobe on the next cycle, and the engine is running the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_i | input | 1 | Software register write strobe |
| sw_addr_i | input | 12 | Software write byte offset |
| sw_wdata_i | input | 32 | Software write data |
| start_i | input | 1 | Start the engine from idle |
| frame_done_i | input | 1 | Engine reports the end of the current frame |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_addr_o | output | 32 | Memory read byte address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data word |
| cfg_o | output | NREG*32 | Flattened configuration slots, slot i at bits 32*i+31:32*i |
| frame_start_o | output | 1 | Strobe that starts the next frame |
| running_o | output | 1 | Engine is processing a frame |
| irq_o | output | 1 | Reload-complete interrupt pulse |
| irq_sticky_o | output | 1 | Sticky copy of the interrupt |
| pending_o | output | 1 | A reload is armed |
| ptr_o | output | 32 | Stored descriptor pointer |

## Verification
A pointer write or frame-end pulse is taken at one clock edge. The pending flag and the first memory request are visible one cycle later. With a memory that accepts at once and answers on the following cycle, each word takes two cycles. The interrupt is therefore seen 2*NREG+1 cycles after the triggering edge, the frame-start strobe one cycle after the interrupt, and the running flag one cycle after that. The bench counts falling edges from the triggering edge and compares the count with this figure. It samples every result on the falling edge of the cycle in which that result is due, and in the stall case it holds ready low for several cycles to observe the request waiting.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int DW = 32;

  localparam logic [11:0] OFF_STAT    = 12'h000;
  localparam logic [11:0] OFF_PTR     = 12'h100;
  localparam logic [11:0] OFF_PTR_SET = 12'h104;
  localparam logic [11:0] OFF_PTR_CLR = 12'h108;
  localparam logic [11:0] OFF_PTR_TOG = 12'h10C;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_FETCH, ST_IRQ, ST_RESTART
  } ctl_state_e;

  // Slots the reload never touches: status, coefficients, pointer, version.
  function automatic logic slot_excluded(input int idx);
    return (idx == 0) || (idx >= 8 && idx <= 10) || (idx == 13) || (idx == 15);
  endfunction

  // Odd slots carry two reserved 5-bit fields at the top of each half-word.
  function automatic logic [DW-1:0] slot_keep(input int idx);
    return (idx % 2 == 1) ? 32'h07FF_07FF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [DW-1:0] slot_addr(input logic [DW-1:0] base, input int idx);
    return base + (32'(idx) << 2);
  endfunction
endpackage

// File: rtl/rl_ptr_reg.sv
module rl_ptr_reg import rl_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_norm,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  input  logic          fetching,
  input  logic          fetch_start,
  input  logic          fetch_done,
  output logic [DW-1:0] ptr_q,
  output logic          pend_q
);
  logic held_q, held_d, pend_d;

  always_comb begin
    pend_d = pend_q;
    held_d = held_q;
    if (fetch_start) held_d = 1'b0;
    if (fetch_done)  pend_d = held_q;
    if (wr_norm) begin
      pend_d = 1'b1;
      if (fetching) held_d = 1'b1;
    end
    if (wr_clr) begin
      pend_d = 1'b0;
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      if (wr_norm) ptr_q <= wdata;
      pend_q <= pend_d;
      held_q <= held_d;
    end
  end

  AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_norm |=> pend_q && ptr_q == $past(wdata)); // R2
  AST_CLEAR_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !pend_q); // R5
endmodule

// File: rtl/rl_fetch.sv
module rl_fetch import rl_pkg::*; #(
  parameter int NREG = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DW-1:0]        base_in,
  output logic                 req_valid,
  output logic [DW-1:0]        req_addr,
  input  logic                 req_ready,
  input  logic                 rsp_valid,
  input  logic [DW-1:0]        rsp_data,
  output logic                 wr_en,
  output logic [$clog2(NREG)-1:0] wr_idx,
  output logic [DW-1:0]        wr_data,
  output logic                 done
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] LAST = IW'(NREG - 1);

  logic          active_q, wait_q, take;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] base_q;

  assign req_valid = active_q && !wait_q;
  assign req_addr  = slot_addr(base_q, int'(idx_q));
  assign take      = active_q && wait_q && rsp_valid;
  assign done      = take && (idx_q == LAST);
  assign wr_en     = take;
  assign wr_idx    = idx_q;
  assign wr_data   = rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= base_in;
    end else begin
      if (req_valid && req_ready) wait_q <= 1'b1;
      if (take) begin
        wait_q <= 1'b0;
        idx_q  <= idx_q + IW'(1);
        if (done) active_q <= 1'b0;
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R7
endmodule

// File: rtl/rl_cfg_bank.sv
module rl_cfg_bank import rl_pkg::*; #(
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  output logic [NREG*DW-1:0]      cfg_o
);
  localparam int IW = $clog2(NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (slot_excluded(g)) begin : g_fixed
      assign cfg_o[g*DW +: DW] = '0;
    end else begin : g_load
      logic [DW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             r_q <= '0;
        else if (wr_en && wr_idx == IW'(g))     r_q <= wr_data & slot_keep(g);
      end
      assign cfg_o[g*DW +: DW] = r_q;
    end
  end
endmodule

// File: rtl/frame_reload_ctrl.sv
module frame_reload_ctrl import rl_pkg::*; #(
  parameter int NREG = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_wr_i,
  input  logic [11:0]          sw_addr_i,
  input  logic [31:0]          sw_wdata_i,
  input  logic                 start_i,
  input  logic                 frame_done_i,
  output logic                 mem_req_valid_o,
  output logic [31:0]          mem_req_addr_o,
  input  logic                 mem_req_ready_i,
  input  logic                 mem_rsp_valid_i,
  input  logic [31:0]          mem_rsp_data_i,
  output logic [NREG*32-1:0]   cfg_o,
  output logic                 frame_start_o,
  output logic                 running_o,
  output logic                 irq_o,
  output logic                 irq_sticky_o,
  output logic                 pending_o,
  output logic [31:0]          ptr_o
);
  localparam int IW = $clog2(NREG);

  ctl_state_e    st_q, st_d;
  logic          wr_norm, wr_clr, wr_set_tog, wr_stat_clr;
  logic          boundary, arm_now, fetching, fetch_start, fetch_done;
  logic          fw_en, sticky_q, pend_q;
  logic [IW-1:0] fw_idx;
  logic [31:0]   fw_data, base_sel, ptr_q;

  // Decoded software events, named for the assertions.
  assign wr_norm     = sw_wr_i && sw_addr_i == OFF_PTR;
  assign wr_clr      = sw_wr_i && sw_addr_i == OFF_PTR_CLR;
  assign wr_set_tog  = sw_wr_i && (sw_addr_i == OFF_PTR_SET || sw_addr_i == OFF_PTR_TOG);
  assign wr_stat_clr = sw_wr_i && sw_addr_i == OFF_STAT && sw_wdata_i[0];

  assign fetching    = st_q == ST_FETCH;
  assign boundary    = st_q == ST_RUN && frame_done_i;
  assign arm_now     = wr_norm || (pend_q && !wr_clr);
  assign fetch_start = (st_q == ST_IDLE && wr_norm) || (boundary && arm_now);
  assign base_sel    = wr_norm ? sw_wdata_i : ptr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (wr_norm) st_d = ST_FETCH;
                  else if (start_i) st_d = ST_RESTART;
      ST_RUN:     if (frame_done_i) st_d = fetch_start ? ST_FETCH : ST_IDLE;
      ST_FETCH:   if (fetch_done) st_d = ST_IRQ;
      ST_IRQ:     st_d = ST_RESTART;
      ST_RESTART: st_d = ST_RUN;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sticky_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IRQ)   sticky_q <= 1'b1;
      else if (wr_stat_clr) sticky_q <= 1'b0;
    end
  end

  assign frame_start_o = st_q == ST_RESTART;
  assign running_o     = st_q == ST_RUN;
  assign irq_o         = st_q == ST_IRQ;
  assign irq_sticky_o  = sticky_q;
  assign pending_o     = pend_q;
  assign ptr_o         = ptr_q;

  rl_ptr_reg u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_norm(wr_norm), .wr_clr(wr_clr),
    .wdata(sw_wdata_i), .fetching(fetching), .fetch_start(fetch_start),
    .fetch_done(fetch_done), .ptr_q(ptr_q), .pend_q(pend_q)
  );

  rl_fetch #(.NREG(NREG)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(fetch_start), .base_in(base_sel),
    .req_valid(mem_req_valid_o), .req_addr(mem_req_addr_o),
    .req_ready(mem_req_ready_i), .rsp_valid(mem_rsp_valid_i),
    .rsp_data(mem_rsp_data_i), .wr_en(fw_en), .wr_idx(fw_idx),
    .wr_data(fw_data), .done(fetch_done)
  );

  rl_cfg_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(fw_en), .wr_idx(fw_idx),
    .wr_data(fw_data), .cfg_o(cfg_o)
  );

  AST_IDLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_IDLE && wr_norm |=> mem_req_valid_o); // R3
  AST_ALIAS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_IDLE && wr_set_tog |=> !mem_req_valid_o && !pending_o); // R4
  AST_DONE_TO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> irq_o); // R6
  AST_IRQ_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> frame_start_o && !irq_o); // R6
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> irq_sticky_o); // R11
  AST_NO_ARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !arm_now |=> !running_o && !frame_start_o); // R12
endmodule

// File: tb/sim_frame_reload_ctrl.sv
module sim_frame_reload_ctrl;
  localparam int NREG    = 16;
  localparam int LAT_IRQ = 2*NREG + 1; // falling edges from trigger edge to interrupt
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 32'h0000_4000}, {1'b1, 32'h0001_2340},
    {1'b0, 32'hFFFF_FFE0}, {1'b1, 32'h8000_0010}
  };

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic sw_wr = 0, start = 0, fdone = 0, mreq_ready = 1;
  logic [11:0] sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic mrsp_valid;
  logic [31:0] mrsp_data;
  logic mreq_valid, fstart, running, irq, sticky, pending;
  logic [31:0] mreq_addr, ptr;
  logic [NREG*32-1:0] cfg;

  int checks = 0, errors = 0, cyc = 0, req_n = 0;
  logic [31:0] req_log [0:255];

  frame_reload_ctrl #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_wr_i(sw_wr), .sw_addr_i(sw_addr),
    .sw_wdata_i(sw_wdata), .start_i(start), .frame_done_i(fdone),
    .mem_req_valid_o(mreq_valid), .mem_req_addr_o(mreq_addr),
    .mem_req_ready_i(mreq_ready), .mem_rsp_valid_i(mrsp_valid),
    .mem_rsp_data_i(mrsp_data), .cfg_o(cfg), .frame_start_o(fstart),
    .running_o(running), .irq_o(irq), .irq_sticky_o(sticky),
    .pending_o(pending), .ptr_o(ptr)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [31:0] exp_slot(input logic [31:0] base, input int i);
    logic [15:0] skip;
    skip = 16'hA701; // slots 0,8,9,10,13,15
    if (skip[i]) return 32'h0;
    return mem_word(base + 32'(4*i)) & ((i % 2 == 1) ? 32'h07FF_07FF : 32'hFFFF_FFFF);
  endfunction

  // Memory model: accepts when ready, answers one cycle later.
  always @(posedge clk) begin
    if (!rst_n) begin
      mrsp_valid <= 1'b0;
      mrsp_data  <= '0;
    end else begin
      mrsp_valid <= mreq_valid && mreq_ready;
      mrsp_data  <= mem_word(mreq_addr);
      if (mreq_valid && mreq_ready) begin
        req_log[req_n % 256] <= mreq_addr;
        req_n <= req_n + 1;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sw_wr = 1; sw_addr = a; sw_wdata = d;
    @(negedge clk); sw_wr = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); fdone = 1;
    @(negedge clk); fdone = 0;
  endtask

  task automatic go_idle();
    if (running) begin
      pulse_done();
      chk("R12 idle after unarmed frame end", {31'd0, running}, 32'd0);
      chk("R12 no frame start", {31'd0, fstart}, 32'd0);
    end
  endtask

  task automatic go_run();
    if (!running) begin
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      chk("R13 frame start after start pulse", {31'd0, fstart}, 32'd1);
      @(negedge clk);
      chk("R13 running", {31'd0, running}, 32'd1);
    end
  endtask

  // Waits for the interrupt; caller sits at the falling edge after the trigger edge.
  task automatic tail(input logic [31:0] base, input bit lat);
    int cnt;
    cnt = 1;
    while (!irq && cnt < 400) begin @(negedge clk); cnt++; end
    if (lat) chk("R6 interrupt latency", 32'(cnt), 32'(LAT_IRQ));
    @(negedge clk);
    chk("R11 interrupt one cycle", {31'd0, irq}, 32'd0);
    chk("R6 frame start after interrupt", {31'd0, fstart}, 32'd1);
    chk("R11 sticky set", {31'd0, sticky}, 32'd1);
    @(negedge clk);
    chk("R6 running after restart", {31'd0, running}, 32'd1);
    for (int i = 0; i < NREG; i++)
      chk($sformatf("R8/R9 slot %0d", i), cfg[i*32 +: 32], exp_slot(base, i));
  endtask

  task automatic order(input logic [31:0] base, input int from);
    for (int i = 0; i < NREG; i++)
      chk($sformatf("R7 request %0d", i), req_log[(from + i) % 256], base + 32'(4*i));
  endtask

  initial begin
    logic [31:0] base, last;
    int from;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cfg zero", 32'(cfg != '0), 32'd0);
    chk("R1 outputs zero", {25'd0, mreq_valid, fstart, running, irq, sticky, pending, 1'b0}, 32'd0);
    chk("R1 pointer zero", ptr, 32'd0);

    for (int v = 0; v < 4; v++) begin
      base = VEC[v][31:0];
      if (VEC[v][32]) begin
        go_run();
        from = req_n;
        wr(12'h100, base);
        chk("R2 pending armed", {31'd0, pending}, 32'd1);
        chk("R2 pointer stored", ptr, base);
        repeat (3) begin
          @(negedge clk);
          chk("R2 no fetch while running", {31'd0, mreq_valid}, 32'd0);
        end
        pulse_done();
      end else begin
        go_idle();
        from = req_n;
        wr(12'h100, base);
        chk("R3 immediate fetch", {31'd0, mreq_valid}, 32'd1);
        chk("R3 first address", mreq_addr, base);
      end
      tail(base, 1);
      chk("R10 pending cleared", {31'd0, pending}, 32'd0);
      order(base, from);
      last = base;
    end

    wr(12'h000, 32'h1);
    chk("R11 sticky cleared", {31'd0, sticky}, 32'd0);

    go_idle();
    wr(12'h104, 32'hDEAD_0000);
    chk("R4 set alias pending", {31'd0, pending}, 32'd0);
    chk("R4 set alias pointer", ptr, last);
    chk("R4 set alias no fetch", {31'd0, mreq_valid}, 32'd0);
    wr(12'h10C, 32'hBEEF_0000);
    chk("R4 toggle alias pointer", ptr, last);
    @(negedge clk);
    chk("R4 toggle alias no fetch", {31'd0, mreq_valid | pending}, 32'd0);

    go_run();
    wr(12'h100, 32'h0000_7700);
    chk("R5 armed before clear", {31'd0, pending}, 32'd1);
    wr(12'h108, 32'h0);
    chk("R5 pending cancelled", {31'd0, pending}, 32'd0);
    pulse_done();
    chk("R5 idle after frame end", {31'd0, running}, 32'd0);
    repeat (4) begin
      @(negedge clk);
      chk("R5 no fetch or interrupt", {30'd0, mreq_valid, irq}, 32'd0);
    end
    chk("R5 cfg unchanged", cfg[32 +: 32], exp_slot(last, 1));

    mreq_ready = 0;
    from = req_n;
    wr(12'h100, 32'h0003_0000);
    repeat (3) begin
      @(negedge clk);
      chk("R7 held request valid", {31'd0, mreq_valid}, 32'd1);
      chk("R7 held request address", mreq_addr, 32'h0003_0000);
    end
    mreq_ready = 1;
    tail(32'h0003_0000, 0);
    order(32'h0003_0000, from);

    go_idle();
    wr(12'h100, 32'h0000_A000);
    repeat (4) @(negedge clk);
    wr(12'h100, 32'h0000_B000);
    chk("R10 pending during fetch", {31'd0, pending}, 32'd1);
    tail(32'h0000_A000, 0);
    chk("R10 held write still pending", {31'd0, pending}, 32'd1);
    chk("R10 held pointer", ptr, 32'h0000_B000);
    pulse_done();
    tail(32'h0000_B000, 1);
    chk("R10 pending cleared after second fetch", {31'd0, pending}, 32'd0);

    summary();
    $finish;
  end
endmodule